// File: doc/BRIEF.md
# Infrared Transmit Pulse Modulator

This block turns a queue of timed pulse entries into an infrared drive signal. Each entry has a level, either mark or space, and a duration counted in ticks of a programmable divided clock. The entries are played back to back. With modulation off, the output simply follows the level, so a mark drives high and a space drives low. With modulation on, one of the two levels is gated with a carrier whose period is 16 ticks and whose high time is programmable in sixteenths. A polarity bit decides whether the marks or the spaces carry the burst.

Software fills the queue through a small write/strobe register port. The block raises a service request when the queue reaches a selectable fill condition, and passes that request to an interrupt output only when the interrupt is enabled. A busy output is high while a pulse is being emitted. When the queue runs dry, the output returns to the idle low level.

Register map (`addr_i`, with data on `wdata_i`):
- Address 0 is the control register:
  - bit0 enables the transmitter.
  - bit1 enables the queue.
  - bit2 enables modulation.
  - bit3 sets the polarity (1 puts the burst on spaces).
  - bit4 selects the watermark (0 = not empty, 1 = half full or less).
  - bit5 enables the interrupt.
- Address 1 holds the divisor D. One tick occurs every D+1 clocks.
- Address 2 holds the duty value N. The carrier is high for N+1 ticks out of 16.
- Address 3 pushes an entry. Bit16 is the level (1 = mark) and bits 15:0 are the tick count.

Top module: `irtx_mod`

## Requirements
- R1: After reset, `ir_o`, `busy_o`, `svc_o` and `irq_o` are all low.
- R2: With modulation off, an entry of level L and count C holds `ir_o` at L (mark = 1) for exactly C*(D+1) clocks while `busy_o` is high. Consecutive entries are emitted with no gap between them.
- R3: An entry pushed with a count of zero is discarded and takes up no time, so the neighbouring entries join up directly.
- R4: When the queue is empty at the end of a pulse, `busy_o` falls and `ir_o` is low. Whenever `busy_o` is low, `ir_o` is low.
- R5: With modulation on and polarity 0, a mark pulse of 32 ticks with duty value N gives exactly 2*(N+1) ticks of high output. A duty value of 15 keeps the output high for the whole mark.
- R6: With modulation on and polarity 1, a mark is silent for its whole length, and a space of 32 ticks with duty value N gives 2*(N+1) high ticks.
- R7: With watermark 0, `svc_o` is high when the queue is not empty. With watermark 1, `svc_o` is high when the fill level is at most half of DEPTH (4 of 8). In both cases `svc_o` is low while the queue is disabled.
- R8: `irq_o` equals `svc_o` when the interrupt is enabled, and is low otherwise.
- R9: While the queue is disabled, its contents are flushed and pushes are ignored.
- R10: While the transmitter is disabled, no entry is consumed and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 17 | Register write data |
| ir_o | output | 1 | Infrared drive output |
| busy_o | output | 1 | High while a pulse is being emitted |
| svc_o | output | 1 | Queue service request |
| irq_o | output | 1 | Service request gated by the interrupt enable |

## Verification
Baseband playback is driven with alternating mark and space entries at a divisor of 2. A scoreboard compares each measured run length against its count times three clocks, which separates off-by-one errors in the divider from errors in the pulse counter. A space/zero/space sequence run at divisor 0 shows whether a zero-count entry merges its neighbours or leaves a stray tick. Modulated 32-tick pulses at several duty values and both polarities count the high ticks, which distinguishes a wrong duty compare, a swapped polarity and a burst placed on the wrong level. Fill-level walks across the half-full boundary in both watermark modes, with the interrupt enable toggled, confirm the request and interrupt outputs.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int CNT_W = 16;
  localparam int DATA_W = CNT_W + 1;

  typedef struct packed {
    logic             mark;
    logic [CNT_W-1:0] cnt;
  } entry_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DUTY = 2'd2;
  localparam logic [1:0] ADDR_PUSH = 2'd3;
endpackage

// File: rtl/irtx_tick_div.sv
module irtx_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  irtx_pkg::entry_t din_i,
  input  logic            pop_i,
  output irtx_pkg::entry_t dout_o,
  output logic            empty_o,
  output logic [LW-1:0]   level_o
);
  irtx_pkg::entry_t mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign dout_o  = mem[rptr_q];
  assign do_push = push_i && (cnt_q < LW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [PH_W-1:0] duty_i,
  output logic            carrier_o
);
  logic [PH_W-1:0] phase_q;

  // high for phases 0..duty, i.e. duty+1 of 2**PH_W ticks
  assign carrier_o = (phase_q <= duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (!en_i)  phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/irtx_mod.sv
module irtx_mod #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PH_W = 4,
  localparam int HALF = DEPTH / 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [1:0]                  addr_i,
  input  logic [irtx_pkg::DATA_W-1:0] wdata_i,
  output logic                        ir_o,
  output logic                        busy_o,
  output logic                        svc_o,
  output logic                        irq_o
);
  import irtx_pkg::*;

  logic tx_en_q, fifo_en_q, mod_en_q, pol_q, wm_sel_q, irq_en_q;
  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {irq_en_q, wm_sel_q, pol_q, mod_en_q, fifo_en_q, tx_en_q} <= '0;
      div_q  <= '0;
      duty_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_CTRL: {irq_en_q, wm_sel_q, pol_q, mod_en_q, fifo_en_q, tx_en_q} <= wdata_i[5:0];
        ADDR_DIV:  div_q  <= wdata_i[DIV_W-1:0];
        ADDR_DUTY: duty_q <= wdata_i[PH_W-1:0];
        default: ;
      endcase
    end
  end

  entry_t        wr_entry, head;
  logic          push, pop, empty, tick, carrier;
  logic [LW-1:0] fifo_lvl;

  assign wr_entry = entry_t'(wdata_i);
  // zero-length entries never enter the queue
  assign push = wr_i && (addr_i == ADDR_PUSH) && fifo_en_q && (wr_entry.cnt != '0);

  irtx_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tx_en_q),
    .div_i (div_q),
    .tick_o(tick)
  );

  irtx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!fifo_en_q),
    .push_i (push),
    .din_i  (wr_entry),
    .pop_i  (pop),
    .dout_o (head),
    .empty_o(empty),
    .level_o(fifo_lvl)
  );

  irtx_carrier #(.PH_W(PH_W)) u_car (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en_q),
    .tick_i   (tick),
    .duty_i   (duty_q),
    .carrier_o(carrier)
  );

  logic             active_q, lvl_q;
  logic [CNT_W-1:0] rem_q;
  logic             last_tick;

  assign last_tick = tick && (rem_q <= CNT_W'(1));
  assign pop       = last_tick && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
      rem_q    <= '0;
    end else if (!tx_en_q) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
      rem_q    <= '0;
    end else if (tick) begin
      if (!last_tick) begin
        rem_q <= rem_q - 1'b1;
      end else if (!empty) begin
        active_q <= 1'b1;
        lvl_q    <= head.mark;
        rem_q    <= head.cnt;
      end else begin
        active_q <= 1'b0;
        lvl_q    <= 1'b0;
        rem_q    <= '0;
      end
    end
  end

  logic burst_lvl;
  assign burst_lvl = pol_q ? !lvl_q : lvl_q;
  assign ir_o   = active_q && (mod_en_q ? (burst_lvl && carrier) : lvl_q);
  assign busy_o = active_q;
  assign svc_o  = fifo_en_q && (wm_sel_q ? (fifo_lvl <= LW'(HALF)) : (fifo_lvl != '0));
  assign irq_o  = svc_o && irq_en_q;
endmodule

// File: rtl/irtx_mod_chk.sv
module irtx_mod_chk #(
  parameter int LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ir_o,
  input logic          busy_o,
  input logic          svc_o,
  input logic          irq_o,
  input logic          tx_en,
  input logic          fifo_en,
  input logic          mod_en,
  input logic          pol,
  input logic          lvl,
  input logic [3:0]    duty,
  input logic          wm_sel,
  input logic [LW-1:0] fifo_lvl
);
  assert_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ir_o);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> svc_o);

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |=> (fifo_lvl == '0));

  assert_tx_off_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> !busy_o);

  assert_full_duty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mod_en && !pol && lvl && duty == 4'hf) |-> ir_o);

  assert_mark_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mod_en && pol && lvl) |-> !ir_o);

  assert_not_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o && !wm_sel) |-> (fifo_lvl != '0));
endmodule

bind irtx_mod irtx_mod_chk #(.LW(LW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ir_o    (ir_o),
  .busy_o  (busy_o),
  .svc_o   (svc_o),
  .irq_o   (irq_o),
  .tx_en   (tx_en_q),
  .fifo_en (fifo_en_q),
  .mod_en  (mod_en_q),
  .pol     (pol_q),
  .lvl     (lvl_q),
  .duty    (duty_q),
  .wm_sel  (wm_sel_q),
  .fifo_lvl(fifo_lvl)
);

// File: tb/irtx_mod_tb.sv
module irtx_mod_tb;
  localparam int TX = 1, FE = 2, MOD = 4, POL = 8, WM = 16, IE = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [16:0] wdata_i = '0;
  logic        ir_o, busy_o, svc_o, irq_o;

  int checks = 0;
  int failures = 0;

  typedef struct { logic lvl; int len; int req; } run_t;
  run_t exp_q[$];

  bit mon_runs = 1'b0;
  bit in_run = 1'b0;
  logic run_lvl = 1'b0;
  int run_len = 0;
  int busy_cnt = 0;
  int ones_cnt = 0;

  always #10 clk_i = ~clk_i;

  irtx_mod u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .ir_o   (ir_o),
    .busy_o (busy_o),
    .svc_o  (svc_o),
    .irq_o  (irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic close_run();
    run_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2 unexpected run", run_len, 0);
    end else begin
      e = exp_q.pop_front();
      chk(run_lvl == e.lvl && run_len == e.len, $sformatf("R%0d run", e.req),
          run_len * 2 + int'(run_lvl), e.len * 2 + int'(e.lvl));
    end
  endtask

  // monitor: measure runs while busy and count modulated high ticks
  always @(negedge clk_i) begin
    if (busy_o) begin
      busy_cnt++;
      if (ir_o) ones_cnt++;
    end
    if (mon_runs) begin
      if (busy_o) begin
        if (!in_run) begin
          in_run = 1'b1; run_lvl = ir_o; run_len = 1;
        end else if (ir_o == run_lvl) begin
          run_len++;
        end else begin
          close_run();
          run_lvl = ir_o; run_len = 1;
        end
      end else if (in_run) begin
        close_run();
        in_run = 1'b0;
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input int d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = 17'(d);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic push(input bit mark, input int cnt);
    reg_wr(2'd3, (int'(mark) << 16) | cnt);
  endtask

  task automatic expect_run(input bit lvl, input int len, input int req);
    run_t e;
    e.lvl = lvl; e.len = len; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_done();
    while (!busy_o) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic mod_pulse(input int ctrl, input int duty, input bit mark, input int exp_ones, input string req);
    reg_wr(2'd0, FE);
    reg_wr(2'd2, duty);
    push(mark, 32);
    busy_cnt = 0; ones_cnt = 0;
    reg_wr(2'd0, ctrl);
    wait_done();
    chk(busy_cnt == 32, {req, " busy length"}, busy_cnt, 32);
    chk(ones_cnt == exp_ones, {req, " high ticks"}, ones_cnt, exp_ones);
    reg_wr(2'd0, FE);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!ir_o && !busy_o && !svc_o && !irq_o, "R1 reset outputs",
        {ir_o, busy_o, svc_o, irq_o}, 0);

    // R2 baseband playback, divisor 2
    reg_wr(2'd1, 2);
    reg_wr(2'd0, FE);
    push(1, 3); push(0, 2); push(1, 1); push(0, 4);
    expect_run(1, 9, 2); expect_run(0, 6, 2); expect_run(1, 3, 2); expect_run(0, 12, 2);
    mon_runs = 1'b1;
    reg_wr(2'd0, TX | FE);
    wait_done();
    chk(exp_q.size() == 0, "R2 all runs seen", exp_q.size(), 0);
    chk(!busy_o && !ir_o, "R4 idle after drain", {busy_o, ir_o}, 0);

    // R3 zero-count entry merges neighbours, divisor 0
    reg_wr(2'd0, FE);
    reg_wr(2'd1, 0);
    push(0, 3); push(1, 0); push(0, 4); push(1, 5);
    expect_run(0, 7, 3); expect_run(1, 5, 3);
    reg_wr(2'd0, TX | FE);
    wait_done();
    chk(exp_q.size() == 0, "R3 all runs seen", exp_q.size(), 0);
    mon_runs = 1'b0;
    reg_wr(2'd0, FE);

    // R5 carrier duty, R6 polarity
    mod_pulse(TX | FE | MOD, 5, 1, 12, "R5 duty5");
    mod_pulse(TX | FE | MOD, 15, 1, 32, "R5 duty15");
    mod_pulse(TX | FE | MOD, 0, 1, 2, "R5 duty0");
    mod_pulse(TX | FE | MOD | POL, 9, 1, 0, "R6 mark silent");
    mod_pulse(TX | FE | MOD | POL, 3, 0, 8, "R6 space burst");

    // R7 watermark modes, R8 interrupt gating
    reg_wr(2'd0, 0);
    reg_wr(2'd0, FE);
    @(negedge clk_i);
    chk(!svc_o, "R7 not-empty mode, empty", svc_o, 0);
    reg_wr(2'd0, FE | WM);
    chk(svc_o, "R7 half mode, empty", svc_o, 1);
    push(1, 7);
    reg_wr(2'd0, FE);
    chk(svc_o, "R7 not-empty mode, one entry", svc_o, 1);
    chk(!irq_o, "R8 irq disabled", irq_o, 0);
    reg_wr(2'd0, FE | IE);
    chk(irq_o, "R8 irq enabled", irq_o, 1);
    reg_wr(2'd0, FE | WM | IE);
    push(1, 7); push(0, 7); push(1, 7);
    chk(svc_o && irq_o, "R7 half mode at 4", {svc_o, irq_o}, 3);
    push(0, 7);
    chk(!svc_o && !irq_o, "R7 half mode at 5", {svc_o, irq_o}, 0);

    // R10 transmitter off: nothing consumed
    repeat (50) @(negedge clk_i);
    chk(!busy_o && !ir_o, "R10 no playback while disabled", {busy_o, ir_o}, 0);
    chk(!svc_o, "R10 level kept at 5", svc_o, 0);

    // R9 queue disabled: flushed, pushes ignored
    reg_wr(2'd0, WM | IE);
    chk(!svc_o && !irq_o, "R7 gated by queue disable", {svc_o, irq_o}, 0);
    push(1, 9);
    reg_wr(2'd0, FE);
    chk(!svc_o, "R9 flushed and push ignored", svc_o, 0);
    busy_cnt = 0;
    reg_wr(2'd0, FE | TX);
    repeat (20) @(negedge clk_i);
    chk(busy_cnt == 0, "R9 nothing to play", busy_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule